// File: doc/BRIEF.md
# Stepped-Phase Cosine/Sine Value Generator

This block supplies the trigonometric weight used by a sample-streaming Fourier transform each time one coefficient slot is updated. No index multiplication takes place. A 6-bit phase register is cleared at the start of a sample's pass over the coefficient slots. It then grows by the current sample number on each step strobe. Slot k of the pass for sample j therefore sees phase k*j modulo 64, where 64 phase units make one full cycle.

The two top phase bits give the quadrant and the low four bits give the position inside it. A sixteen-entry quarter-wave cosine table is read with a mirrored address in two of the four quadrants. The result is a full-cycle cosine as an unsigned magnitude plus a negative flag. Full scale is 128, which matches a later divide-by-128 after the product. A select input changes the output to sine by offsetting the looked-up phase by a quarter cycle. The phase register itself does not change.

Top module: `trig_step_gen`

## Requirements
- R1: While reset is held, the phase is 0, so the cosine output is magnitude 128 with the negative flag low.
- R2: A restart pulse sets the phase to 0 at the next clock edge. Restart takes priority over a step in the same cycle.
- R3: A step without restart adds the sample number to the phase modulo 64 at the next edge. With neither strobe, the phase holds whatever the sample number input does.
- R4: After a restart followed by k steps at sample number j, the outputs give the value for phase k*j mod 64.
- R5: With select low (cosine), the magnitude equals round(128*|cos(2*pi*p/64)|) for phase p. It is exactly 128 at p = 0 and 32, and exactly 0 at p = 16 and 48.
- R6: The negative flag follows the quadrant taken from phase bits 5:4. For cosine it is high in quadrants 1 and 2. It is never high when the magnitude is 0.
- R7: With select high (sine), the outputs equal the cosine values at phase p-16 mod 64. The magnitude is 128 at p = 16 and 48 and 0 at p = 0 and 32. The flag is high for p in 33..63.
- R8: The cos/sin select acts only on the outputs. Toggling it without a strobe leaves the phase unchanged.
- R9: The magnitude never exceeds 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Clear phase at start of a coefficient pass |
| step | input | 1 | Advance phase by the sample number |
| sample_idx | input | 6 | Current sample number (phase increment) |
| sel_sin | input | 1 | 0 selects cosine, 1 selects sine |
| mag | output | 8 | Unsigned magnitude, full scale 128 |
| neg | output | 1 | High when the value is negative |

## Verification
Every cycle, the bound checker tests the phase register transitions for restart, step and hold. It also checks the 128 limit on the magnitude, that a zero magnitude never carries the negative flag, and the exact axis values at the quarter points. The magnitude at every phase and the product relation k*j across whole passes can only be shown by the bench's scenarios. The same holds for the sine offset and for the select having no effect on the phase. The bench sweeps every sample number through a full pass in both cosine and sine mode and compares against a floating-point reference.

// File: rtl/trig_step_gen.sv
module trig_step_gen #(
  parameter int PHASE_W = 6,
  parameter int MAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               step,
  input  logic [PHASE_W-1:0] sample_idx,
  input  logic               sel_sin,
  output logic [MAG_W-1:0]   mag,
  output logic               neg
);
  localparam int OFF_W = PHASE_W - 2;
  localparam logic [PHASE_W-1:0] QTR = PHASE_W'(1) << OFF_W;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] look;
  logic [1:0]         quad;
  logic [OFF_W-1:0]   off, addr;
  logic               on_axis;

  function automatic int qwave(input logic [OFF_W-1:0] a);
    case (int'(a))
      0:  return 128;
      1:  return 127;
      2:  return 126;
      3:  return 122;
      4:  return 118;
      5:  return 113;
      6:  return 106;
      7:  return 99;
      8:  return 91;
      9:  return 81;
      10: return 71;
      11: return 60;
      12: return 49;
      13: return 37;
      14: return 25;
      15: return 13;
      default: return 0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (step)    phase_q <= phase_q + sample_idx;
  end

  assign look    = sel_sin ? phase_q - QTR : phase_q;
  assign quad    = look[PHASE_W-1 -: 2];
  assign off     = look[OFF_W-1:0];
  assign addr    = quad[0] ? -off : off;
  assign on_axis = quad[0] && (off == '0);
  assign mag     = on_axis ? '0 : MAG_W'(qwave(addr));
  assign neg     = (quad[1] ^ quad[0]) && !on_axis;
endmodule

// File: rtl/trig_step_gen_chk.sv
module trig_step_gen_chk #(
  parameter int PHASE_W = 6,
  parameter int MAG_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               restart,
  input logic               step,
  input logic [PHASE_W-1:0] sample_idx,
  input logic               sel_sin,
  input logic [MAG_W-1:0]   mag,
  input logic               neg,
  input logic [PHASE_W-1:0] phase
);
  localparam logic [PHASE_W-1:0] QTR = PHASE_W'(1) << (PHASE_W - 2);

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> phase == '0);

  a_r3_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && step) |=> phase == PHASE_W'($past(phase) + $past(sample_idx)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> $stable(phase));

  a_r9_max_mag: assert property (@(posedge clk) disable iff (!rst_n)
    mag <= MAG_W'(128));

  a_r6_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |-> !neg);

  a_r5_cos_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_sin && phase == '0) |-> (mag == MAG_W'(128) && !neg));

  a_r7_sin_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sin && phase == QTR) |-> (mag == MAG_W'(128) && !neg));
endmodule

bind trig_step_gen trig_step_gen_chk #(.PHASE_W(PHASE_W), .MAG_W(MAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
  .sample_idx(sample_idx), .sel_sin(sel_sin), .mag(mag), .neg(neg),
  .phase(phase_q)
);

// File: tb/trig_step_gen_tb_top.sv
`timescale 1ns/1ps
module trig_step_gen_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       restart = 0, step = 0, sel_sin = 0;
  logic [5:0] sample_idx = '0;
  logic [7:0] mag;
  logic       neg;

  int nchk = 0, nfail = 0;
  int m_phase = 0;
  bit done = 0;

  typedef struct { int ph; bit s; string tag; } item_t;
  item_t q[$];

  trig_step_gen dut_i (.clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .sample_idx(sample_idx), .sel_sin(sel_sin), .mag(mag), .neg(neg));

  always #5 clk = ~clk;

  function automatic void ref_val(input int p, input bit s, output int m, output bit n);
    int pp;
    real a;
    pp = s ? ((p - 16) & 63) : p;
    a = 128.0 * $cos(2.0 * 3.14159265358979 * pp / 64.0);
    m = (a < 0.0) ? $rtoi(-a + 0.5) : $rtoi(a + 0.5);
    n = (a < 0.0) && (m != 0);
  endfunction

  task automatic compare(input int p, input bit s, input string tag);
    int em;
    bit en;
    ref_val(p, s, em, en);
    nchk++;
    if (mag !== 8'(em) || neg !== en) begin
      nfail++;
      $display("FAIL %s phase=%0d sel=%0d: mag=%0d neg=%0d expected mag=%0d neg=%0d",
               tag, p, s, mag, neg, em, en);
    end
  endtask

  task automatic drive(input bit rs, input bit st, input int idx, input bit s, input string tag);
    item_t it;
    @(negedge clk);
    restart = rs; step = st; sample_idx = 6'(idx); sel_sin = s;
    if (rs) m_phase = 0;
    else if (st) m_phase = (m_phase + idx) & 63;
    it.ph = m_phase; it.s = s; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      compare(it.ph, it.s, it.tag);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, 0, "R1 reset cos");
    sel_sin = 1;
    @(negedge clk);
    compare(0, 1, "R1 reset sin");
    sel_sin = 0;
    rst_n = 1;

    for (int j = 0; j < 64; j++) begin
      drive(1, 0, j, 0, "R2 R4 R5 R6 cos restart");
      for (int k = 1; k <= 64; k++) drive(0, 1, j, 0, "R3 R4 R5 R6 cos pass");
    end
    for (int j = 0; j < 64; j++) begin
      drive(1, 0, j, 1, "R2 R4 R7 sin restart");
      for (int k = 1; k <= 64; k++) drive(0, 1, j, 1, "R3 R4 R7 sin pass");
    end

    drive(1, 0, 0, 0, "R2 restart");
    drive(0, 1, 5, 0, "R3 step");
    drive(1, 1, 9, 0, "R2 restart beats step");
    drive(0, 1, 16, 0, "R5 axis 16");
    drive(0, 1, 16, 0, "R5 peak 32");
    drive(0, 1, 16, 0, "R5 axis 48");
    for (int i = 0; i < 6; i++) drive(0, 0, 7 * i + 3, 0, "R3 hold ignores idx");
    drive(0, 1, 3, 0, "R3 step after hold");
    for (int i = 0; i < 8; i++) drive(0, 0, 0, i[0], "R8 select toggle");
    drive(0, 1, 20, 1, "R7 sin after toggle");
    drive(0, 1, 63, 1, "R3 wrap");
    drive(1, 0, 0, 1, "R7 sin at 0");
    drive(0, 1, 32, 1, "R7 sin at 32");
    drive(0, 1, 16, 1, "R7 sin at 48");
    drive(0, 0, 0, 0, "R8 cos after sin");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R4 queue not drained: %0d left, expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule